// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the incoming byte stream and decides whether each frame should be kept. It captures the six destination-address bytes, runs a CRC-32 over them on the fly and classifies the frame. The possible classes are own-station unicast, broadcast, hash-selected multicast, and anything taken because promiscuous mode is on. The classification is then combined with a six-bit accept mask. Runt and errored frames are discarded unless the mask explicitly lets them through.

Configuration is written through a small word-addressed write port. The port holds the station address, a 64-bit multicast hash table and the accept mask. The frame arrives one byte per valid cycle, with start and end markers; error and runt flags travel with the end byte. One cycle after the end byte, a single-cycle verdict carries the accept decision and the class code.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, verdict_valid and verdict_accept are 0, the station address and hash table are all zeros, and the accept mask is 0x0E (station, multicast and broadcast accept on; promiscuous, runt and error accept off).
- R2: A write with reg_we high is effective from the next cycle. Word 0 holds station bytes 0..3, with byte 0 (the first destination byte on the wire) in bits 7:0. Word 1 holds bytes 4 and 5 in bits 7:0 and 15:8. Word 2 holds hash bits 31:0, word 3 holds hash bits 63:32, and word 4 holds the accept mask in bits 5:0.
- R3: verdict_valid is high for exactly the one cycle that follows each cycle with rx_valid and rx_eof both high, and is low at all other times. verdict_accept is never high without verdict_valid.
- R4: A frame whose six destination bytes are all 0xFF is broadcast. Class 2 is reported when mask bit 3 is set. A broadcast frame is never treated as multicast.
- R5: A non-broadcast frame whose first destination byte has bit 0 set is multicast. The hash index is bits 31:26 of a CRC-32 over the six destination bytes, computed as follows. The register starts at all ones and takes each byte LSB first. For each bit: feedback = crc[31] xor bit, crc is shifted left one place, and if feedback is 1 it is then xored with 0x04C11DB7. There is no final inversion. Index bit 5 selects the hash word (1 means bits 63:32), and index bits 4:0 select the bit within that word. Class 3 is reported when mask bit 2 is set and the selected hash bit is 1.
- R6: A non-multicast frame whose destination equals the station address reports class 1 when mask bit 1 is set.
- R7: A frame that earns none of classes 1 to 3 reports class 4 (promiscuous) when mask bit 0 is set, and class 0 otherwise. Accept is 0 whenever the class is 0.
- R8: With the hash table all ones and mask bit 2 set, every multicast frame reports class 3.
- R9: A frame is a runt when rx_runt is high with its end byte, or when it ends before six bytes have arrived. A frame of fewer than six bytes earns none of classes 1 to 3. A runt is rejected unless mask bit 4 is set; the class is still reported.
- R10: A frame with rx_err high with its end byte is rejected unless mask bit 5 is set; the class is still reported.
- R11: Bytes after the sixth do not change the destination address or the hash index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_addr | input | 3 | Configuration word address |
| reg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_err | input | 1 | Frame errored, sampled with the end byte |
| rx_runt | input | 1 | Frame is a runt, sampled with the end byte |
| verdict_valid | output | 1 | Verdict strobe, one cycle |
| verdict_accept | output | 1 | 1 = keep the frame |
| verdict_class | output | 3 | 0 none, 1 station, 2 broadcast, 3 multicast, 4 promiscuous |

## Verification
The assertions assume that the reset cycles carry no end-of-frame byte. They also assume that the error and runt flags are only meaningful with the end byte, and that the accept mask seen at the end byte is the one the verdict must obey. The bench keeps to these assumptions. It holds rx_valid low during reset and drives every frame as one unbroken run of valid bytes starting with rx_sof. It raises the flags only on the end byte. It changes configuration only between frames, so no write can race a verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {
    CLS_NONE    = 3'd0,
    CLS_UCAST   = 3'd1,
    CLS_BCAST   = 3'd2,
    CLS_MCAST   = 3'd3,
    CLS_PROMISC = 3'd4
  } rxf_class_e;

  // Fold one byte, least significant bit first, into a shift-left CRC.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < BYTE_W; k++) begin
      fb = r[CRC_W-1] ^ b[k];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 64,
  parameter int MODE_W     = 6,
  parameter int RA_W       = 3,
  parameter logic [MODE_W-1:0] MODE_RST = 6'h0E
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [RA_W-1:0]         addr,
  input  logic [31:0]             wdata,
  output logic [ADDR_BYTES*8-1:0] station,
  output logic [HASH_W-1:0]       hash,
  output logic [MODE_W-1:0]       mode
);
  localparam int HWORDS   = HASH_W / 32;
  localparam int ST_W     = ADDR_BYTES * 8;
  localparam int ST_WORDS = (ST_W + 31) / 32;
  localparam int ST_PAD   = ST_WORDS * 32;
  localparam int HASH_A0  = ST_WORDS;
  localparam int MODE_A   = HASH_A0 + HWORDS;

  logic [ST_PAD-1:0] st_q;
  logic [31:0]       hw_q [HWORDS];
  logic [MODE_W-1:0] mode_q;

  // Station words
  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else if (we && int'(addr) < ST_WORDS)
      st_q[int'(addr)*32 +: 32] <= wdata;
  end

  // Hash words, one register per word
  for (genvar g = 0; g < HWORDS; g++) begin : g_hash
    always_ff @(posedge clk) begin
      if (rst) hw_q[g] <= '0;
      else if (we && int'(addr) == HASH_A0 + g) hw_q[g] <= wdata;
    end
    assign hash[g*32 +: 32] = hw_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RST;
    else if (we && int'(addr) == MODE_A) mode_q <= wdata[MODE_W-1:0];
  end

  assign station = st_q[ST_W-1:0];
  assign mode    = mode_q;

  logic unused_cfg;
  assign unused_cfg = ^{st_q[ST_PAD-1:ST_W], wdata[31:MODE_W]};
endmodule

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [BYTE_W-1:0]       rx_data,
  output logic [ADDR_BYTES*8-1:0] da_now,
  output logic [CRC_W-1:0]        crc_now,
  output logic                    da_full
);
  logic [BYTE_W-1:0] da_q   [ADDR_BYTES];
  logic [BYTE_W-1:0] da_n   [ADDR_BYTES];
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_n;
  logic [CRC_W-1:0]  crc_q, crc_base, crc_n;
  logic              take;

  // View of the address state including the byte presented this cycle
  always_comb begin
    cnt_base = (rx_valid && rx_sof) ? '0 : cnt_q;
    crc_base = (rx_valid && rx_sof) ? '1 : crc_q;
    take     = rx_valid && (cnt_base < CNT_W'(ADDR_BYTES));
    cnt_n    = cnt_base;
    crc_n    = crc_base;
    for (int i = 0; i < ADDR_BYTES; i++) da_n[i] = da_q[i];
    if (take) begin
      cnt_n = cnt_base + 1'b1;
      crc_n = crc_fold(crc_base, rx_data);
      for (int i = 0; i < ADDR_BYTES; i++)
        if (CNT_W'(i) == cnt_base) da_n[i] = rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      crc_q <= '1;
      for (int i = 0; i < ADDR_BYTES; i++) da_q[i] <= '0;
    end else if (rx_valid) begin
      cnt_q <= cnt_n;
      crc_q <= crc_n;
      for (int i = 0; i < ADDR_BYTES; i++) da_q[i] <= da_n[i];
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_flat
    assign da_now[g*8 +: 8] = da_n[g];
  end
  assign crc_now = crc_n;
  assign da_full = (cnt_n == CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 64,
  parameter int MODE_W     = 6,
  localparam int HIDX_W    = $clog2(HASH_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    eof_now,
  input  logic                    err_in,
  input  logic                    runt_in,
  input  logic [ADDR_BYTES*8-1:0] da,
  input  logic [CRC_W-1:0]        crc,
  input  logic                    da_full,
  input  logic [ADDR_BYTES*8-1:0] station,
  input  logic [HASH_W-1:0]       hash,
  input  logic [MODE_W-1:0]       mode,
  output logic                    v_valid,
  output logic                    v_accept,
  output logic [2:0]              v_class
);
  localparam int M_PROM = 0, M_UCAST = 1, M_MCAST = 2, M_BCAST = 3,
                 M_RUNT = 4, M_ERR = 5;

  logic             is_bcast, is_mcast, is_own, hash_hit, is_runt, blocked;
  logic [HIDX_W-1:0] hidx;
  rxf_class_e       cls;

  always_comb begin
    hidx     = crc[CRC_W-1 -: HIDX_W];
    hash_hit = hash[hidx];
    is_bcast = da_full && (&da);
    is_mcast = da_full && da[0] && !is_bcast;
    is_own   = da_full && !da[0] && (da == station);
    is_runt  = runt_in || !da_full;

    if (is_bcast && mode[M_BCAST])                   cls = CLS_BCAST;
    else if (is_mcast && mode[M_MCAST] && hash_hit)  cls = CLS_MCAST;
    else if (is_own && mode[M_UCAST])                cls = CLS_UCAST;
    else if (mode[M_PROM])                           cls = CLS_PROMISC;
    else                                             cls = CLS_NONE;

    blocked = (is_runt && !mode[M_RUNT]) || (err_in && !mode[M_ERR]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_valid  <= 1'b0;
      v_accept <= 1'b0;
      v_class  <= CLS_NONE;
    end else begin
      v_valid  <= eof_now;
      v_accept <= eof_now && (cls != CLS_NONE) && !blocked;
      v_class  <= eof_now ? cls : CLS_NONE;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 64,
  parameter int MODE_W     = 6,
  parameter int RA_W       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_data,
  input  logic            rx_err,
  input  logic            rx_runt,
  output logic            verdict_valid,
  output logic            verdict_accept,
  output logic [2:0]      verdict_class
);
  localparam int DA_W = ADDR_BYTES * 8;

  logic [DA_W-1:0]   station_q, da_now;
  logic [HASH_W-1:0] hash_q;
  logic [MODE_W-1:0] mode_q;
  logic [CRC_W-1:0]  crc_now;
  logic              da_full;

  rxf_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W), .MODE_W(MODE_W),
             .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .station(station_q), .hash(hash_q), .mode(mode_q)
  );

  rxf_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .da_now(da_now), .crc_now(crc_now), .da_full(da_full)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W),
               .MODE_W(MODE_W)) u_dec (
    .clk(clk), .rst(rst), .eof_now(rx_valid && rx_eof),
    .err_in(rx_err), .runt_in(rx_runt), .da(da_now), .crc(crc_now),
    .da_full(da_full), .station(station_q), .hash(hash_q), .mode(mode_q),
    .v_valid(verdict_valid), .v_accept(verdict_accept),
    .v_class(verdict_class)
  );
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int MODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_eof,
  input logic              rx_err,
  input logic              rx_runt,
  input logic [MODE_W-1:0] mode,
  input logic              verdict_valid,
  input logic              verdict_accept,
  input logic [2:0]        verdict_class
);
  assert_valid_follows_eof_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (verdict_valid == $past(rx_valid && rx_eof)));

  assert_accept_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !verdict_valid |-> !verdict_accept);

  assert_accept_has_class_R7: assert property (@(posedge clk) disable iff (rst)
    verdict_accept |-> (verdict_class != 3'd0));

  assert_promisc_needs_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && verdict_valid && verdict_class == 3'd4) |-> $past(mode[0]));

  assert_runt_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_valid && rx_eof && rx_runt && !mode[4]))
      |-> !verdict_accept);

  assert_err_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_valid && rx_eof && rx_err && !mode[5]))
      |-> !verdict_accept);

  assert_class_range_R5: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (verdict_class <= 3'd4));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .rx_err(rx_err), .rx_runt(rx_runt), .mode(mode_q),
  .verdict_valid(verdict_valid), .verdict_accept(verdict_accept),
  .verdict_class(verdict_class)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0, rx_runt = 0;
  logic [7:0] rx_data = 0;
  logic verdict_valid, verdict_accept;
  logic [2:0] verdict_class;
  int checks = 0, fails = 0;
  bit done = 0;
  logic got_acc; logic [2:0] got_cls;

  always #4 clk = ~clk;

  rx_addr_filter u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = da[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = c[31] ^ b[k];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  // da: byte 0 on the wire in bits 47:40
  task automatic send(input logic [47:0] da, input int len,
                      input bit err, input bit runt);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 2) chk("R3 idle mid-frame", verdict_valid, 0);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data  = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
      rx_err   = err && (i == len - 1);
      rx_runt  = runt && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_runt = 0;
    chk("R3 verdict strobe", verdict_valid, 1);
    got_acc = verdict_accept; got_cls = verdict_class;
    @(negedge clk);
    chk("R3 strobe one cycle", verdict_valid, 0);
    chk("R3 accept low", verdict_accept, 0);
  endtask

  task automatic expect_v(string req, logic [47:0] da, int len, bit e, bit r,
                          int acc, int cls);
    send(da, len, e, r);
    chk({req, " accept"}, got_acc, acc);
    chk({req, " class"}, got_cls, cls);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", verdict_valid, 0);
    chk("R1 accept after reset", verdict_accept, 0);
    expect_v("R1 default bcast", 48'hFFFFFFFFFFFF, 20, 0, 0, 1, 2);
    expect_v("R1 zero station", 48'h000000000000, 20, 0, 0, 1, 1);
    expect_v("R1 empty hash", 48'h01005E000001, 20, 0, 0, 0, 0);
  endtask

  task automatic t_bcast;
    wr(4, 32'h06);
    expect_v("R4 bcast off", 48'hFFFFFFFFFFFF, 20, 0, 0, 0, 0);
    wr(2, 32'hFFFFFFFF); wr(3, 32'hFFFFFFFF);
    expect_v("R4 bcast not mcast", 48'hFFFFFFFFFFFF, 20, 0, 0, 0, 0);
    wr(4, 32'h0E);
    expect_v("R4 bcast on", 48'hFFFFFFFFFFFF, 8, 0, 0, 1, 2);
    wr(2, 0); wr(3, 0);
  endtask

  task automatic t_ucast;
    wr(0, 32'h33221102); wr(1, 32'h00005544);
    expect_v("R6 R2 own match", 48'h021122334455, 20, 0, 0, 1, 1);
    expect_v("R6 last byte differs", 48'h021122334456, 20, 0, 0, 0, 0);
    expect_v("R11 exact six bytes", 48'h021122334455, 6, 0, 0, 1, 1);
    wr(4, 32'h0C);
    expect_v("R6 station off", 48'h021122334455, 20, 0, 0, 0, 0);
    wr(4, 32'h0E);
  endtask

  task automatic t_mcast;
    logic [47:0] d1 = 48'h01005E000001, d2 = 48'h01005E000001;
    logic [5:0]  i1 = hidx(d1);
    for (int x = 2; x < 256; x++) begin
      d2 = {40'h01005E0000, 8'(x)};
      if (hidx(d2) != i1) break;
    end
    wr(i1[5] ? 3 : 2, 32'(1) << i1[4:0]);
    expect_v("R5 hash hit", d1, 64, 0, 0, 1, 3);
    expect_v("R5 hash miss", d2, 64, 0, 0, 0, 0);
    wr(i1[5] ? 3 : 2, 0);
    wr(i1[5] ? 2 : 3, 32'(1) << i1[4:0]);
    expect_v("R5 R2 wrong word", d1, 64, 0, 0, 0, 0);
    wr(2, 0); wr(3, 0);
  endtask

  task automatic t_allones;
    wr(2, 32'hFFFFFFFF); wr(3, 32'hFFFFFFFF);
    expect_v("R8 mcast a", 48'h01005E7F0102, 20, 0, 0, 1, 3);
    expect_v("R8 mcast b", 48'h333300000001, 20, 0, 0, 1, 3);
    expect_v("R8 mcast c", 48'hFFFFFFFFFFFE, 20, 0, 0, 1, 3);
    wr(4, 32'h0A);
    expect_v("R8 mcast off", 48'h333300000001, 20, 0, 0, 0, 0);
    wr(4, 32'h0E); wr(2, 0); wr(3, 0);
  endtask

  task automatic t_promisc;
    wr(4, 32'h01);
    expect_v("R7 other ucast", 48'h0A0B0C0D0E0F, 20, 0, 0, 1, 4);
    expect_v("R7 bcast via promisc", 48'hFFFFFFFFFFFF, 20, 0, 0, 1, 4);
    wr(4, 32'h0F);
    expect_v("R7 own wins", 48'h021122334455, 20, 0, 0, 1, 1);
    wr(4, 32'h0E);
    expect_v("R7 no class", 48'h0A0B0C0D0E0F, 20, 0, 0, 0, 0);
  endtask

  task automatic t_runt;
    expect_v("R9 runt flag drop", 48'hFFFFFFFFFFFF, 20, 0, 1, 0, 2);
    expect_v("R9 short default", 48'hFFFFFFFFFFFF, 4, 0, 0, 0, 0);
    wr(4, 32'h0F);
    expect_v("R9 short promisc drop", 48'hFFFFFFFFFFFF, 3, 0, 0, 0, 4);
    wr(4, 32'h1F);
    expect_v("R9 short promisc keep", 48'hFFFFFFFFFFFF, 1, 0, 0, 1, 4);
    wr(4, 32'h1E);
    expect_v("R9 runt flag keep", 48'hFFFFFFFFFFFF, 20, 0, 1, 1, 2);
    expect_v("R9 R10 runt ok err not", 48'hFFFFFFFFFFFF, 20, 1, 1, 0, 2);
    wr(4, 32'h0E);
  endtask

  task automatic t_err;
    expect_v("R10 err drop", 48'h021122334455, 20, 1, 0, 0, 1);
    wr(4, 32'h2E);
    expect_v("R10 err keep", 48'h021122334455, 20, 1, 0, 1, 1);
    wr(4, 32'h0E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset; t_bcast; t_ucast; t_mcast; t_allones; t_promisc; t_runt; t_err;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule